// File: doc/BRIEF.md
# Halfword Read Buffer for a Double-Width Memory

This block connects a requester that reads and writes 16-bit halfwords to a memory whose data path is twice as wide. Every memory read brings in a full 32-bit word. The block keeps that word, together with its word address, in a single entry. A later read of the other half of the same word is served from that entry without a memory cycle. A stream of sequential halfword reads therefore needs only half as many memory reads.

Writes stay 16 bits wide. The halfword is copied onto both halves of the memory data bus, and only the byte enables of the addressed half are raised. A write is never merged into the held word. Any accepted write clears the entry instead, so the next read always goes to memory.

Only one request is in flight at a time. The controller has three states:
- `ST_IDLE`: the request port is ready, and a read hit is answered in place.
- `ST_RD_WAIT`: a read miss is fetching the word from memory.
- `ST_WR_WAIT`: a write is being carried to memory.

It has five transitions:
- IDLE→IDLE when there is no request or the request is a read hit.
- IDLE→RD_WAIT when a read miss is accepted.
- IDLE→WR_WAIT when a write is accepted.
- RD_WAIT→IDLE when the memory acknowledges the read.
- WR_WAIT→IDLE when the memory acknowledges the write.

Top module: `hrb_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0. The entry is empty, so the first read is always a miss.
- R2: On an accepted read miss, in the next cycle `mem_req`=1 and `mem_we`=0. `mem_be` is all ones and `mem_addr` is `req_addr[ADDR_W-1:2]`. `req_ready` stays 0 until the memory cycle ends, and exactly one memory read is made.
- R3: After a miss, `rsp_valid` rises in the cycle that follows the cycle in which `mem_ack` is high.
- R4: `req_addr[1]`=0 returns word bits 15:0, and `req_addr[1]`=1 returns bits 31:16. `req_addr[0]` is ignored.
- R5: An accepted read hits when the entry is valid and `req_addr[ADDR_W-1:2]` equals the stored word address. A hit raises `rsp_valid` in the next cycle and makes no memory cycle.
- R6: The whole fetched word is kept, so after a miss on one half, a read of the other half of the same word is a hit.
- R7: An accepted write, in the next cycle, drives `mem_req`=1, `mem_we`=1 and `mem_wdata`={data,data}. It drives `mem_be`=4'b0011 for `req_addr[1]`=0 and 4'b1100 for `req_addr[1]`=1. It gives no response and keeps `req_ready` at 0 until `mem_ack`.
- R8: Any accepted write clears the entry, whatever its address. The next read then misses and returns the memory contents, never a merged copy.
- R9: While `mem_req` is high without `mem_ack`, `mem_req`, `mem_we`, `mem_be` and `mem_addr` hold their values into the next cycle.
- R10: Read hits can be accepted in consecutive cycles, and each returns its halfword one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request port can accept |
| req_write | input | 1 | 1 = halfword write, 0 = halfword read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | HALF_W | Write halfword |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_rdata | output | HALF_W | Read halfword |
| mem_req | output | 1 | Memory cycle request, held until acknowledge |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data, halfword on both halves |
| mem_ack | input | 1 | Memory cycle complete |
| mem_rdata | input | 32 | Read word, valid with `mem_ack` |

## Verification
The bench builds the block with `ADDR_W`=8 and `HALF_W`=16. This gives a 64-word memory model that the bench fully owns, so the lowest and the highest word address can both be reached. The memory model answers with a two-cycle latency. This makes the busy window of each miss and each write long enough to see the port held not-ready, and to see the request held stable.

// File: rtl/hrb_pkg.sv
package hrb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_WR_WAIT = 2'd2
    } hrb_state_e;

endpackage

// File: rtl/hrb_ctrl.sv
module hrb_ctrl
    import hrb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic hit,
    input  logic mem_ack,
    output logic req_ready,
    output logic rd_hit_go,
    output logic rd_miss_go,
    output logic wr_go,
    output logic fill,
    output logic mem_req,
    output logic mem_we
);

    hrb_state_e state_q, state_d;
    logic       take;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && req_write)      state_d = ST_WR_WAIT;
                else if (req_valid && !hit)      state_d = ST_RD_WAIT;
            end
            ST_RD_WAIT: if (mem_ack) state_d = ST_IDLE;
            ST_WR_WAIT: if (mem_ack) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        fill       = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_RD_WAIT: begin
                mem_req = 1'b1;
                fill    = mem_ack;
            end
            ST_WR_WAIT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
        take       = req_valid && req_ready;
        rd_hit_go  = take && !req_write && hit;
        rd_miss_go = take && !req_write && !hit;
        wr_go      = take && req_write;
    end

endmodule

// File: rtl/hrb_tag_cmp.sv
module hrb_tag_cmp #(
    parameter int TAG_W = 14
) (
    input  logic             entry_vld,
    input  logic [TAG_W-1:0] entry_tag,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit
);

    assign hit = entry_vld && (entry_tag == look_tag);

endmodule

// File: rtl/hrb_half_sel.sv
module hrb_half_sel #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] word,
    input  logic                upper,
    output logic [HALF_W-1:0]   half
);

    assign half = upper ? word[2*HALF_W-1:HALF_W] : word[HALF_W-1:0];

endmodule

// File: rtl/hrb_wr_lane.sv
module hrb_wr_lane #(
    parameter  int HALF_W = 16,
    localparam int HBE_W  = HALF_W / 8
) (
    input  logic [HALF_W-1:0]   half,
    input  logic                upper,
    output logic [2*HALF_W-1:0] wdata,
    output logic [2*HBE_W-1:0]  be
);

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign wdata[g*HALF_W +: HALF_W] = half;
        assign be[g*HBE_W +: HBE_W]      = {HBE_W{upper == 1'(g)}};
    end

endmodule

// File: rtl/hrb_top.sv
module hrb_top #(
    parameter  int ADDR_W = 16,
    parameter  int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W,
    localparam int BE_W   = WORD_W / 8,
    localparam int OFS_W  = $clog2(BE_W),
    localparam int TAG_W  = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HALF_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [HALF_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [TAG_W-1:0]  mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);

    localparam int SEL = OFS_W - 1;

    logic              hit, rd_hit_go, rd_miss_go, wr_go, fill;
    logic [TAG_W-1:0]  look_tag;
    logic              look_sel;
    logic              addr_unused;

    // Held request
    logic [TAG_W-1:0]  cur_tag_q;
    logic              cur_sel_q;
    logic [HALF_W-1:0] cur_wdata_q;

    // Buffer entry
    logic [WORD_W-1:0] ent_word_q;
    logic [TAG_W-1:0]  ent_tag_q;
    logic              ent_vld_q;

    // Response path
    logic [WORD_W-1:0] src_word;
    logic              src_sel;
    logic [HALF_W-1:0] src_half;
    logic [WORD_W-1:0] lane_wdata;
    logic [BE_W-1:0]   lane_be;

    assign look_tag    = req_addr[ADDR_W-1:OFS_W];
    assign look_sel    = req_addr[SEL];
    assign addr_unused = ^req_addr[SEL:0];

    hrb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .hit        (hit),
        .mem_ack    (mem_ack),
        .req_ready  (req_ready),
        .rd_hit_go  (rd_hit_go),
        .rd_miss_go (rd_miss_go),
        .wr_go      (wr_go),
        .fill       (fill),
        .mem_req    (mem_req),
        .mem_we     (mem_we)
    );

    hrb_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
        .entry_vld (ent_vld_q),
        .entry_tag (ent_tag_q),
        .look_tag  (look_tag),
        .hit       (hit)
    );

    // A fill and an in-place hit never coincide: one needs RD_WAIT, the other IDLE.
    assign src_word = fill ? mem_rdata : ent_word_q;
    assign src_sel  = fill ? cur_sel_q : look_sel;

    hrb_half_sel #(.HALF_W(HALF_W)) u_sel (
        .word  (src_word),
        .upper (src_sel),
        .half  (src_half)
    );

    hrb_wr_lane #(.HALF_W(HALF_W)) u_lane (
        .half  (cur_wdata_q),
        .upper (cur_sel_q),
        .wdata (lane_wdata),
        .be    (lane_be)
    );

    always_ff @(posedge clk) begin
        if (rd_miss_go || wr_go) begin
            cur_tag_q   <= look_tag;
            cur_sel_q   <= look_sel;
            cur_wdata_q <= req_wdata;
        end
        if (fill) begin
            ent_word_q <= mem_rdata;
            ent_tag_q  <= cur_tag_q;
        end
        rsp_rdata <= src_half;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld_q <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            if (wr_go)     ent_vld_q <= 1'b0;
            else if (fill) ent_vld_q <= 1'b1;
            rsp_valid <= rd_hit_go || fill;
        end
    end

    assign mem_addr  = cur_tag_q;
    assign mem_be    = mem_we ? lane_be : {BE_W{1'b1}};
    assign mem_wdata = lane_wdata;

endmodule

// File: rtl/hrb_chk.sv
module hrb_chk #(
    parameter  int ADDR_W = 16,
    parameter  int HALF_W = 16,
    localparam int BE_W   = (2 * HALF_W) / 8,
    localparam int TAG_W  = ADDR_W - $clog2(BE_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic             rsp_valid,
    input logic             mem_req,
    input logic             mem_we,
    input logic [TAG_W-1:0] mem_addr,
    input logic [BE_W-1:0]  mem_be,
    input logic             mem_ack
);

    localparam logic [BE_W-1:0] LO_BE = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
    localparam logic [BE_W-1:0] HI_BE = ~LO_BE;

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be));

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R2
    rd_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_be == {BE_W{1'b1}});

    // R7
    wr_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_be == LO_BE || mem_be == HI_BE));

    // R7
    wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write |=> mem_req && mem_we && !rsp_valid);

    // R3
    fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=> rsp_valid);

    // R5
    rd_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_write |=> rsp_valid || (mem_req && !mem_we));

endmodule

bind hrb_top hrb_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_ack   (mem_ack)
);

// File: tb/tb_hrb_top.sv
`timescale 1ns/1ps
module tb_hrb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int HALF_W     = 16;
    localparam int TAG_W      = ADDR_W - 2;
    localparam int WORDS      = 1 << TAG_W;
    localparam int LAT        = 2;

    logic              clk, rst_n;
    logic              req_valid, req_ready, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [15:0]       req_wdata;
    logic              rsp_valid;
    logic [15:0]       rsp_rdata;
    logic              mem_req, mem_we, mem_ack;
    logic [TAG_W-1:0]  mem_addr;
    logic [3:0]        mem_be;
    logic [31:0]       mem_wdata, mem_rdata;

    hrb_top #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] mem_model [WORDS];
    logic [15:0] exp_q [$];
    logic             tb_vld = 1'b0;
    logic [TAG_W-1:0] tb_tag = '0;

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Memory responder
    initial begin
        int wait_c;
        wait_c = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        for (int i = 0; i < WORDS; i++)
            mem_model[i] = 32'h5A00_0000 ^ (i * 32'h0103_0507) ^ {16'(i), 16'(~i)};
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                wait_c++;
                if (wait_c >= LAT) begin
                    wait_c = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        wr_cnt++;
                        for (int b = 0; b < 4; b++)
                            if (mem_be[b]) mem_model[mem_addr][8*b +: 8] = mem_wdata[8*b +: 8];
                    end else begin
                        rd_cnt++;
                        mem_rdata = mem_model[mem_addr];
                    end
                end
            end
        end
    end

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && rsp_valid) begin
                if (exp_q.size() == 0) chk("R4", "unexpected response", 32'(rsp_rdata), 32'hFFFF_FFFF);
                else chk("R4", "rsp_rdata", 32'(rsp_rdata), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    task automatic tick;
        @(negedge clk); #1;
    endtask

    task automatic wait_idle;
        int g = 0;
        while (!req_ready && g < 100) begin tick(); g++; end
        if (!req_ready) chk("R2", "ready never returned", 0, 1);
    endtask

    function automatic logic [15:0] model_half(input logic [ADDR_W-1:0] a);
        return a[1] ? mem_model[a[ADDR_W-1:2]][31:16] : mem_model[a[ADDR_W-1:2]][15:0];
    endfunction

    task automatic do_read(input logic [ADDR_W-1:0] a, input string rq);
        logic [TAG_W-1:0] w = a[ADDR_W-1:2];
        bit   hit = tb_vld && (tb_tag == w);
        int   r0;
        logic prev_ack = 1'b0;
        int   g = 0;
        wait_idle();
        r0 = rd_cnt;
        exp_q.push_back(model_half(a));
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        tick();
        req_valid = 1'b0;
        if (hit) begin
            chk(rq, "hit rsp_valid next cycle (R5)", 32'(rsp_valid), 1);
            chk(rq, "hit makes no memory cycle (R5)", 32'(mem_req), 0);
            chk(rq, "hit read count (R5)", rd_cnt, r0);
        end else begin
            chk(rq, "miss issues read (R2)", {29'd0, mem_req, mem_we, req_ready}, 32'b100);
            chk(rq, "miss be/addr (R2)", {mem_be, 2'b00, mem_addr}, {4'hF, 2'b00, w});
            while (!rsp_valid && g < 100) begin prev_ack = mem_ack; tick(); g++; end
            chk(rq, "rsp one cycle after ack (R3)", 32'(prev_ack), 1);
            chk(rq, "one memory read per miss (R2)", rd_cnt, r0 + 1);
            tb_vld = 1'b1; tb_tag = w;
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [15:0] d, input string rq);
        int w0;
        wait_idle();
        w0 = wr_cnt;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        tick();
        req_valid = 1'b0; req_write = 1'b0;
        chk(rq, "write cycle (R7)", {29'd0, mem_req, mem_we, rsp_valid}, 32'b110);
        chk(rq, "write lanes (R7)", 32'(mem_be), a[1] ? 32'hC : 32'h3);
        chk(rq, "write data (R7)", mem_wdata, {d, d});
        chk(rq, "write addr (R7)", 32'(mem_addr), 32'(a[ADDR_W-1:2]));
        wait_idle();
        chk(rq, "one memory write (R7)", wr_cnt, w0 + 1);
        tb_vld = 1'b0;
    endtask

    task automatic do_hit_pair(input logic [ADDR_W-1:0] a1, input logic [ADDR_W-1:0] a2);
        wait_idle();
        exp_q.push_back(model_half(a1));
        exp_q.push_back(model_half(a2));
        req_valid = 1'b1; req_write = 1'b0; req_addr = a1;
        tick();
        chk("R10", "first back-to-back hit", {30'd0, rsp_valid, req_ready}, 32'b11);
        req_addr = a2;
        tick();
        req_valid = 1'b0;
        chk("R10", "second back-to-back hit", {30'd0, rsp_valid, mem_req}, 32'b10);
    endtask

    initial begin
        int r0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) tick();
        chk("R1", "reset outputs", {29'd0, req_ready, rsp_valid, mem_req}, 32'b100);
        rst_n = 1'b1;
        tick();

        do_read(8'h10, "R1");          // empty entry: miss
        do_read(8'h12, "R6");          // other half: hit
        do_read(8'h11, "R4");          // bit 0 ignored, low half hit
        do_read(8'h22, "R4");          // miss, upper half first
        do_read(8'h20, "R6");
        do_hit_pair(8'h22, 8'h20);

        do_write(8'h40, 16'hBEEF, "R7"); // unrelated word, low half
        do_read(8'h20, "R8");            // must miss
        do_write(8'h22, 16'h1234, "R7"); // held word, upper half
        do_read(8'h20, "R8");            // miss, low half untouched
        do_read(8'h22, "R8");            // hit, value from memory
        do_read(8'h40, "R8");
        do_read(8'h42, "R5");

        do_read(8'hFE, "R2");            // highest word
        do_read(8'h00, "R2");            // lowest word
        do_read(8'h02, "R5");

        r0 = rd_cnt;
        for (int w = 8; w < 16; w++) begin
            do_read(ADDR_W'(4 * w), "R5");
            do_read(ADDR_W'(4 * w + 2), "R5");
        end
        chk("R5", "sequential reads halve memory reads", rd_cnt - r0, 8);

        repeat (3) tick();
        chk("R3", "all responses delivered", exp_q.size(), 0);
        report();
    end

endmodule